// File: doc/BRIEF.md
# Pipelined Constant-Fraction Distance Scaler

This block turns a 20-bit unsigned count, taken from a counter register, into a distance in centimetres. The distance is the count multiplied by 0.00034, which is 680/2,000,000. The datapath has no divider. The fraction is scaled up by 2^F and rounded to an integer constant when the design is elaborated. Each result is then the count times that constant, with the low F bits dropped. For the default F = 16 the constant is 22; a larger F gives more precision, and F = 24 gives 5704.

The count is registered on entry. A second register captures the shifted product, so the only logic between two registers is one multiplication by a constant. A valid strobe travels with the data. A result appears two cycles after its count was presented, and a new count can be accepted on every cycle. With the default settings the output is 9 bits wide, because a full-scale count scales to 351.

Top module: `distScaler`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, `distance` is cleared to 0 and `outValid` is held low from the next clock edge.
- R2: A count presented with `inValid` high at clock edge k gives `outValid` high after edge k+2. When `inValid` was low at edge k, `outValid` is low after edge k+2.
- R3: Each result equals floor(count × K / 2^F), where K = round(680 × 2^F / 2,000,000). K is 22 for F = 16.
- R4: Each result stays between 0 and a fixed bound below floor(count × 680 / 2,000,000). The bound is ceil((2^20 − 1) × |K/2^F − 680/2,000,000|) + 1, which is 6 for F = 16.
- R5: A count of 0 gives a distance of 0.
- R6: While no result is being delivered, `distance` keeps its last value. A count presented with `inValid` low has no effect on `distance`.
- R7: Counts presented on consecutive cycles each produce one result, also on consecutive cycles and in the same order.
- R8: The full-scale count 1048575 gives 351 with the default parameters, and `distance` never exceeds that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `countIn` as a new sample |
| countIn | input | IN_W (20) | Unsigned count to convert |
| outValid | output | 1 | Marks `distance` as a new result |
| distance | output | OUT_W (9) | Distance in centimetres |

## Verification
The bench drives a count of 0, the full-scale count and random counts. A constant rounded or truncated the wrong way, or a shift by the wrong amount, would show up as a result that differs from floor(count × K / 2^F) or that falls outside the error bound. Back-to-back counts would expose a stage that stalls, skips or reorders results. Pulses on the input with `inValid` low would expose a register that loads without its enable, because `distance` would change with no result being delivered. Checking `outValid` one cycle early and exactly on time catches a pipeline that is one stage short or one stage long.

// File: rtl/scalerPkg.sv
package scalerPkg;

  localparam longint FRACTION_NUM = 680;
  localparam longint FRACTION_DEN = 2000000;

  typedef struct packed {
    logic loadIn;
    logic loadOut;
  } ctrlStrobes_t;

  // round(680 * 2^f / 2e6)
  function automatic longint scaleConst(input int f);
    longint scaled;
    scaled = FRACTION_NUM * (longint'(1) << f);
    return (scaled + FRACTION_DEN / 2) / FRACTION_DEN;
  endfunction

  function automatic int constWidth(input int f);
    return $clog2(scaleConst(f) + 1);
  endfunction

  function automatic int outWidth(input int inW, input int f);
    longint maxProd;
    maxProd = ((longint'(1) << inW) - 1) * scaleConst(f);
    return $clog2((maxProd >> f) + 1);
  endfunction

endpackage

// File: rtl/scalerCtrl.sv
module scalerCtrl
  import scalerPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  localparam int STAGES = 2;

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strobes.loadIn  = inValid;
    strobes.loadOut = validPipe[0];
  end

  assign outValid = validPipe[STAGES-1];

  // R1
  reset_valid_chk: assert property (@(posedge clk) rst |=> !outValid);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##1 outValid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ##1 !outValid);

endmodule

// File: rtl/scalerDatapath.sv
module scalerDatapath
  import scalerPkg::*;
#(
  parameter int IN_W      = 20,
  parameter int FRAC_BITS = 16,
  parameter int OUT_W     = outWidth(IN_W, FRAC_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [IN_W-1:0]  countIn,
  output logic [OUT_W-1:0] distance
);

  localparam int            K_W     = constWidth(FRAC_BITS);
  localparam int            PROD_W  = IN_W + K_W;
  localparam logic [K_W-1:0] K_VAL  = K_W'(scaleConst(FRAC_BITS));
  localparam logic [OUT_W-1:0] MAX_OUT =
    OUT_W'((((longint'(1) << IN_W) - 1) * scaleConst(FRAC_BITS)) >> FRAC_BITS);

  logic [IN_W-1:0]   countReg;
  logic [PROD_W-1:0] product;

  always_ff @(posedge clk) begin
    if (rst)                 countReg <= '0;
    else if (strobes.loadIn) countReg <= countIn;
  end

  // Single constant multiply between the two registers
  assign product = PROD_W'(countReg) * PROD_W'(K_VAL);

  always_ff @(posedge clk) begin
    if (rst)                  distance <= '0;
    else if (strobes.loadOut) distance <= OUT_W'(product >> FRAC_BITS);
  end

  // R1
  reset_dist_chk: assert property (@(posedge clk) rst |=> distance == '0);

  // R6
  hold_dist_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadOut |=> $stable(distance));

  // R8
  range_dist_chk: assert property (@(posedge clk) disable iff (rst)
    distance <= MAX_OUT);

endmodule

// File: rtl/distScaler.sv
module distScaler
  import scalerPkg::*;
#(
  parameter int IN_W      = 20,
  parameter int FRAC_BITS = 16,
  parameter int OUT_W     = outWidth(IN_W, FRAC_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  countIn,
  output logic             outValid,
  output logic [OUT_W-1:0] distance
);

  ctrlStrobes_t strobes;

  scalerCtrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  scalerDatapath #(
    .IN_W      (IN_W),
    .FRAC_BITS (FRAC_BITS),
    .OUT_W     (OUT_W)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .countIn  (countIn),
    .distance (distance)
  );

endmodule

// File: tb/test_distScaler.sv
`timescale 1ns/1ps
module test_distScaler;

  localparam int IN_W  = 20;
  localparam int FRAC  = 16;
  localparam int OUT_W = 9;
  localparam longint FULL = (longint'(1) << IN_W) - 1;

  logic             clk = 1'b0;
  logic             rst;
  logic             inValid;
  logic [IN_W-1:0]  countIn;
  logic             outValid;
  logic [OUT_W-1:0] distance;

  int checks = 0;
  int fails  = 0;
  longint kConst;
  longint errBound;

  always #2.5 clk = ~clk;

  distScaler #(.IN_W(IN_W), .FRAC_BITS(FRAC)) i_distScaler (
    .clk(clk), .rst(rst), .inValid(inValid), .countIn(countIn),
    .outValid(outValid), .distance(distance)
  );

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic longint expScaled(input longint x);
    return (x * kConst) >> FRAC;
  endfunction

  function automatic longint trueFloor(input longint x);
    return (x * 680) / 2000000;
  endfunction

  task automatic checkResult(input longint x, input string req);
    longint diff;
    check(outValid == 1'b1, {req, " valid"}, outValid, 1);
    check(distance == expScaled(x), {req, " R3 exact"}, distance, expScaled(x));
    diff = trueFloor(x) - longint'(distance);
    check(diff >= 0 && diff <= errBound, {req, " R4 bound"}, distance, trueFloor(x));
  endtask

  // One count, checks latency and value
  task automatic applyOne(input longint x, input string req);
    @(negedge clk); countIn = IN_W'(x); inValid = 1'b1;
    @(negedge clk); inValid = 1'b0;
    check(outValid == 1'b0, "R2 early", outValid, 0);
    @(negedge clk);
    checkResult(x, req);
    @(negedge clk);
    check(outValid == 1'b0, "R2 single pulse", outValid, 0);
  endtask

  task automatic testReset();
    rst = 1'b1; inValid = 1'b0; countIn = '0;
    repeat (3) @(negedge clk);
    check(distance == '0, "R1 distance", distance, 0);
    check(outValid == 1'b0, "R1 outValid", outValid, 0);
    rst = 1'b0;
  endtask

  task automatic testZeroAndFull();
    applyOne(0, "R5 zero");
    check(distance == 0, "R5 zero value", distance, 0);
    applyOne(FULL, "R8 full scale");
    check(distance == 351, "R8 full value", distance, 351);
  endtask

  task automatic testHold();
    longint held;
    applyOne(500000, "R6 setup");
    held = distance;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); countIn = IN_W'(1000 + i * 150000); inValid = 1'b0;
      check(distance == held, "R6 hold", distance, held);
      check(outValid == 1'b0, "R6 no valid", outValid, 0);
    end
  endtask

  task automatic testBackToBack();
    longint vals[8];
    for (int i = 0; i < 8; i++) vals[i] = (longint'(i) * 131071 + 777) & FULL;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i >= 2) checkResult(vals[i-2], "R7 stream");
      if (i < 8) begin countIn = IN_W'(vals[i]); inValid = 1'b1; end
      else inValid = 1'b0;
    end
    @(negedge clk);
    check(outValid == 1'b0, "R7 stream end", outValid, 0);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 150; i++)
      applyOne(longint'($urandom_range(0, int'(FULL))), "R3 random");
    applyOne(FULL - 1, "R4 near full");
    applyOne(1, "R3 one");
    applyOne(5883, "R4 boundary");
  endtask

  task automatic testResetMidStream();
    @(negedge clk); countIn = IN_W'(900000); inValid = 1'b1;
    @(negedge clk); inValid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(distance == 0, "R1 mid reset", distance, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R1 flushed", outValid, 0);
  endtask

  initial begin
    longint num, den, d;
    kConst = (680 * (longint'(1) << FRAC) + 1000000) / 2000000;
    d = kConst * 2000000 - 680 * (longint'(1) << FRAC);
    if (d < 0) d = -d;
    num = FULL * d;
    den = (longint'(1) << FRAC) * 2000000;
    errBound = (num + den - 1) / den + 1;
    check(kConst == 22, "R3 constant", kConst, 22);
    testReset();
    testZeroAndFull();
    testHold();
    testBackToBack();
    testRandom();
    testResetMidStream();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule